// File: doc/BRIEF.md
# Time-Stamp Resequencing Crosspoint

One crosspoint of an output column in a crosspoint-buffered switch. Cells reach the crosspoint from two places: its own input line writes into a local crosspoint queue, and the crosspoint directly above passes cells down into a transit queue. Each clock is one cell time. In each clock the crosspoint may forward at most one cell, either to the transit queue of the crosspoint below or, at the foot of the column, to the output line. It chooses the cell by comparing time stamps, so that cells that entered the switch earlier leave earlier even though they travelled different paths. Chaining crosspoints top to bottom turns the column into a tree of two-way ordered merges.

Every input line sends a dummy cell in each cell time that carries no traffic. A dummy carries only the current time stamp. It lets a lower merge tell that nothing older is still on its way. A dummy never takes a queue slot of its own: the next cell to arrive replaces it. Backpressure runs upward. A transit queue whose slots all hold real cells tells the crosspoint above to stop. When two real cells have equal stamps, the choice between them is random and weighted by the crosspoint's position in the column, so that each input line gets a fair share of the output.

Top module: `tsq_xpoint`

## Requirements
- R1: After reset both queues are empty, `dn_vld` is 0 and `up_nack` is 0.
- R2: At a position other than the top (POS_K > 1), nothing is forwarded while either queue is empty, even when the other queue holds a cell.
- R3: While `dn_nack` is 1, `dn_vld` is 0 and no queue entry is removed.
- R4: At most one cell is forwarded per clock. A cell is removed from its queue only in the clock in which it is shown on the `dn_*` outputs. Every real cell written is forwarded exactly once.
- R5: When both head cells are real and their stamps differ, the older stamp is forwarded first. Stamps are TS_W-bit values compared modulo 2^TS_W: a is older than b when bit TS_W-1 of (a - b) is 1. For example, 254 is older than 2.
- R6: When both head cells are real and their stamps are equal, the crosspoint cell wins with probability close to 1/POS_K and the transit cell wins otherwise.
- R7: When one head is a dummy and the other is real, the older stamp wins. When the stamps are equal, the real cell wins.
- R8: When both heads are dummies, the older one is forwarded with `dn_dummy` = 1. When the stamps are equal, one dummy is forwarded and both heads are removed.
- R9: A cell written to a queue whose last entry is a dummy replaces that dummy instead of taking a new slot. This does not apply when that dummy is the only entry and is being removed in the same clock. Any number of back-to-back dummies therefore never raises `up_nack`.
- R10: `up_nack` is 1 exactly when the transit queue holds DEPTH entries and its last entry is real. It rises in the clock after the write that fills the queue and falls in the clock after the first removal.
- R11: At the top position (POS_K = 1) there is no transit queue. The crosspoint head is forwarded in every clock in which it exists and `dn_nack` is 0. The `up_*` inputs have no effect and `up_nack` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input line writes a cell into the crosspoint queue |
| in_dummy | input | 1 | Input cell is a dummy |
| in_ts | input | TS_W | Input cell time stamp |
| in_tag | input | TAG_W | Input cell identifier, stands in for the payload |
| up_vld | input | 1 | Crosspoint above writes a cell into the transit queue |
| up_dummy | input | 1 | Cell from above is a dummy |
| up_ts | input | TS_W | Time stamp of the cell from above |
| up_tag | input | TAG_W | Identifier of the cell from above |
| up_nack | output | 1 | Transit queue is full of real cells; the crosspoint above must hold |
| dn_nack | input | 1 | Queue below is full; hold all forwarding |
| dn_vld | output | 1 | A cell is forwarded at the end of this cycle |
| dn_dummy | output | 1 | Forwarded cell is a dummy |
| dn_ts | output | TS_W | Forwarded cell time stamp |
| dn_tag | output | TAG_W | Forwarded cell identifier |

## Verification
The bench fills both queues while the path below holds them. It then releases them and expects one merged stream in stamp order. A merge that picked by queue rather than by age would interleave the two queues wrongly. A comparator without modular arithmetic would send the wrapped stamp 2 ahead of 254. The dummy cases are driven on purpose: equal-stamp real against dummy on each side, dummy against dummy with and without equal stamps, and a long run of dummies into the transit queue. A design that let dummies take slots would raise backpressure after that run. A design that removed only one of two equal dummies would forward a stale dummy one cycle later. Hundreds of equal-stamp real ties are counted. A tie-break that ignored the position would show a crosspoint win rate near one half rather than one third.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    parameter int TS_W   = 8;
    parameter int TAG_W  = 8;
    parameter int LFSR_W = 16;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic             dummy;
        logic [TS_W-1:0]  ts;
        logic [TAG_W-1:0] tag;
    } cell_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_XP   = 2'd1,
        SEL_TR   = 2'd2,
        SEL_BOTH = 2'd3
    } sel_e;

    // a is older than b when the modular difference is negative
    function automatic logic ts_older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
        logic [TS_W-1:0] d;
        d = a - b;
        return d[TS_W-1];
    endfunction

    // Choice between crosspoint head and transit head for one cell time
    function automatic sel_e pick(input logic hold,
                                  input logic xv, input cell_t xh,
                                  input logic tv, input cell_t th,
                                  input logic coin);
        if (hold || !xv || !tv)           return SEL_NONE;
        if (xh.ts != th.ts)               return ts_older(xh.ts, th.ts) ? SEL_XP : SEL_TR;
        if (xh.dummy && th.dummy)         return SEL_BOTH;
        if (xh.dummy)                     return SEL_TR;
        if (th.dummy)                     return SEL_XP;
        return coin ? SEL_XP : SEL_TR;
    endfunction

endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo
    import tsq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  cell_t wr_cell,
    input  logic  rd_en,
    output cell_t head,
    output logic  nonempty,
    output logic  nack
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    cell_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, tail_idx;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             tail_dummy_q, tail_dummy_n;
    logic             ovw, push, nack_n;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        tail_idx     = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
        ovw          = wr_en && (cnt != '0) && tail_dummy_q &&
                       !(rd_en && (cnt == CNT_W'(1)));
        push         = wr_en && !ovw && ((cnt != FULL) || rd_en);
        cnt_n        = cnt + CNT_W'(push) - CNT_W'(rd_en);
        if (push || ovw)
            tail_dummy_n = wr_cell.dummy;
        else if (cnt_n == '0)
            tail_dummy_n = 1'b0;
        else
            tail_dummy_n = tail_dummy_q;
        nack_n       = (cnt_n == FULL) && !tail_dummy_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr       <= '0;
            rd_ptr       <= '0;
            cnt          <= '0;
            tail_dummy_q <= 1'b0;
            nack         <= 1'b0;
        end else begin
            if (push)  wr_ptr <= step(wr_ptr);
            if (rd_en) rd_ptr <= step(rd_ptr);
            cnt          <= cnt_n;
            tail_dummy_q <= tail_dummy_n;
            nack         <= nack_n;
        end
    end

    always_ff @(posedge clk) begin
        if (ovw)
            mem[tail_idx] <= wr_cell;
        else if (push)
            mem[wr_ptr] <= wr_cell;
    end

    assign head     = mem[rd_ptr];
    assign nonempty = (cnt != '0);

endmodule

// File: rtl/tsq_lfsr.sv
module tsq_lfsr
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= LFSR_SEED;
        else if (state[0])
            state <= (state >> 1) ^ LFSR_TAPS;
        else
            state <= state >> 1;
    end
endmodule

// File: rtl/tsq_xpoint.sv
module tsq_xpoint
    import tsq_pkg::*;
#(
    parameter int POS_K = 2,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_dummy,
    input  logic [TS_W-1:0]  in_ts,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             up_vld,
    input  logic             up_dummy,
    input  logic [TS_W-1:0]  up_ts,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_nack,
    input  logic             dn_nack,
    output logic             dn_vld,
    output logic             dn_dummy,
    output logic [TS_W-1:0]  dn_ts,
    output logic [TAG_W-1:0] dn_tag
);
    localparam int K_EFF = (POS_K < 1) ? 1 : POS_K;
    localparam logic [LFSR_W:0] TIE_THR = (LFSR_W + 1)'((2 ** LFSR_W) / K_EFF);

    cell_t             in_cell, xp_head, tr_head, out_cell;
    logic              xp_ne, xp_rd, coin;
    logic              unused_xp_nack;
    logic [LFSR_W-1:0] rnd;
    sel_e              sel;

    assign in_cell = '{dummy: in_dummy, ts: in_ts, tag: in_tag};

    tsq_fifo #(.DEPTH(DEPTH)) u_xp (
        .clk(clk), .rst(rst),
        .wr_en(in_vld), .wr_cell(in_cell),
        .rd_en(xp_rd), .head(xp_head),
        .nonempty(xp_ne), .nack(unused_xp_nack)
    );

    tsq_lfsr u_rnd (.clk(clk), .rst(rst), .state(rnd));

    assign coin = ({1'b0, rnd} < TIE_THR);

    generate
        if (K_EFF == 1) begin : g_top
            logic unused_top;
            assign unused_top = ^{up_vld, up_dummy, up_ts, up_tag, coin};
            assign tr_head    = '0;
            assign up_nack    = 1'b0;
            assign sel        = (xp_ne && !dn_nack) ? SEL_XP : SEL_NONE;
        end else begin : g_mid
            cell_t up_cell;
            logic  tr_ne, tr_rd;
            assign up_cell = '{dummy: up_dummy, ts: up_ts, tag: up_tag};
            assign tr_rd   = (sel == SEL_TR) || (sel == SEL_BOTH);
            tsq_fifo #(.DEPTH(DEPTH)) u_tr (
                .clk(clk), .rst(rst),
                .wr_en(up_vld), .wr_cell(up_cell),
                .rd_en(tr_rd), .head(tr_head),
                .nonempty(tr_ne), .nack(up_nack)
            );
            assign sel = pick(dn_nack, xp_ne, xp_head, tr_ne, tr_head, coin);
        end
    endgenerate

    assign xp_rd    = (sel == SEL_XP) || (sel == SEL_BOTH);
    assign out_cell = (sel == SEL_TR) ? tr_head : xp_head;
    assign dn_vld   = (sel != SEL_NONE);
    assign dn_dummy = out_cell.dummy;
    assign dn_ts    = out_cell.ts;
    assign dn_tag   = out_cell.tag;

endmodule

// File: rtl/tsq_xpoint_chk.sv
module tsq_xpoint_chk
    import tsq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            up_vld,
    input logic            up_dummy,
    input logic            up_nack,
    input logic            dn_nack,
    input logic            dn_vld,
    input logic [TS_W-1:0] dn_ts
);
    logic [TS_W-1:0] last_ts;
    logic            seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            last_ts <= '0;
        end else if (dn_vld) begin
            seen    <= 1'b1;
            last_ts <= dn_ts;
        end
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!dn_vld && !up_nack));

    // R3
    hold_below_chk: assert property (@(posedge clk) disable iff (rst)
        dn_nack |-> !dn_vld);

    // R10
    nack_real_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(up_nack) |-> $past(up_vld && !up_dummy));

    // R5
    stamp_order_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_vld && seen) |-> !ts_older(dn_ts, last_ts));

endmodule

bind tsq_xpoint tsq_xpoint_chk u_chk (
    .clk(clk), .rst(rst),
    .up_vld(up_vld), .up_dummy(up_dummy), .up_nack(up_nack),
    .dn_nack(dn_nack), .dn_vld(dn_vld), .dn_ts(dn_ts)
);

// File: tb/sim_tsq_xpoint.sv
module sim_tsq_xpoint;
    import tsq_pkg::*;

    localparam int CLK_NS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_NS / 2) clk = ~clk;

    logic             a_in_vld = 0, a_in_dummy = 0, a_up_vld = 0, a_up_dummy = 0, a_dn_nack = 0;
    logic [TS_W-1:0]  a_in_ts = 0, a_up_ts = 0;
    logic [TAG_W-1:0] a_in_tag = 0, a_up_tag = 0;
    logic             a_up_nack, a_dn_vld, a_dn_dummy;
    logic [TS_W-1:0]  a_dn_ts;
    logic [TAG_W-1:0] a_dn_tag;

    logic             b_in_vld = 0, b_in_dummy = 0, b_up_vld = 0, b_up_dummy = 0, b_dn_nack = 0;
    logic [TS_W-1:0]  b_in_ts = 0, b_up_ts = 0;
    logic [TAG_W-1:0] b_in_tag = 0, b_up_tag = 0;
    logic             b_up_nack, b_dn_vld, b_dn_dummy;
    logic [TS_W-1:0]  b_dn_ts;
    logic [TAG_W-1:0] b_dn_tag;

    tsq_xpoint #(.POS_K(3), .DEPTH(4)) u0 (
        .clk(clk), .rst(rst),
        .in_vld(a_in_vld), .in_dummy(a_in_dummy), .in_ts(a_in_ts), .in_tag(a_in_tag),
        .up_vld(a_up_vld), .up_dummy(a_up_dummy), .up_ts(a_up_ts), .up_tag(a_up_tag),
        .up_nack(a_up_nack), .dn_nack(a_dn_nack),
        .dn_vld(a_dn_vld), .dn_dummy(a_dn_dummy), .dn_ts(a_dn_ts), .dn_tag(a_dn_tag)
    );

    tsq_xpoint #(.POS_K(1), .DEPTH(4)) u1 (
        .clk(clk), .rst(rst),
        .in_vld(b_in_vld), .in_dummy(b_in_dummy), .in_ts(b_in_ts), .in_tag(b_in_tag),
        .up_vld(b_up_vld), .up_dummy(b_up_dummy), .up_ts(b_up_ts), .up_tag(b_up_tag),
        .up_nack(b_up_nack), .dn_nack(b_dn_nack),
        .dn_vld(b_dn_vld), .dn_dummy(b_dn_dummy), .dn_ts(b_dn_ts), .dn_tag(b_dn_tag)
    );

    int n_chk = 0;
    int n_err = 0;
    bit sb_on = 1'b1;
    bit done  = 1'b0;
    logic [15:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Scoreboard monitor: each real cell leaving u0 must match the next expected one (R4, R5)
    always @(negedge clk) begin
        if (!rst && sb_on && a_dn_vld && !a_dn_dummy) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R4: actual=%0d expected=none (unexpected cell)", a_dn_ts);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if ({a_dn_ts, a_dn_tag} != e) begin
                    n_err++;
                    $display("FAIL R5: actual=%0d/%0d expected=%0d/%0d",
                             a_dn_ts, a_dn_tag, e[15:8], e[7:0]);
                end
            end
        end
    end

    task automatic expect_cell(input logic [7:0] ts, input logic [7:0] tag);
        exp_q.push_back({ts, tag});
    endtask

    task automatic put(input logic xv, input logic xd, input logic [7:0] xts, input logic [7:0] xtag,
                       input logic tv, input logic td, input logic [7:0] tts, input logic [7:0] ttag);
        a_in_vld = xv; a_in_dummy = xd; a_in_ts = xts; a_in_tag = xtag;
        a_up_vld = tv; a_up_dummy = td; a_up_ts = tts; a_up_tag = ttag;
        @(posedge clk); #1;
        a_in_vld = 0; a_up_vld = 0;
    endtask

    task automatic putx(input logic d, input logic [7:0] ts, input logic [7:0] tag);
        put(1, d, ts, tag, 0, 0, 0, 0);
    endtask

    task automatic putt(input logic d, input logic [7:0] ts, input logic [7:0] tag);
        put(0, 0, 0, 0, 1, d, ts, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] t;
        int xw;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #2;
        // R1
        chk(!a_dn_vld, "R1 dn_vld", a_dn_vld, 0);
        chk(!a_up_nack, "R1 up_nack", a_up_nack, 0);
        chk(!b_dn_vld, "R1 top dn_vld", b_dn_vld, 0);
        chk(!b_up_nack, "R1 top up_nack", b_up_nack, 0);
        idle(1);

        // Merge of two queues held by backpressure (R3, R5)
        for (int i = 1; i <= 6; i++) expect_cell(8'(i), 8'(i));
        a_dn_nack = 1;
        put(1, 0, 1, 1, 1, 0, 2, 2);
        put(1, 0, 4, 4, 1, 0, 3, 3);
        put(1, 0, 6, 6, 1, 0, 5, 5);
        #2;
        chk(!a_dn_vld, "R3 hold", a_dn_vld, 0);
        a_dn_nack = 0;
        idle(6);
        putt(1, 7, 0);
        idle(1);
        #2;
        // R2: crosspoint empty, transit holds a dummy
        chk(!a_dn_vld, "R2 one side empty", a_dn_vld, 0);
        putx(1, 8, 0);
        #2;
        // R8 older dummy
        chk(a_dn_vld && a_dn_dummy && a_dn_ts == 7, "R8 older dummy ts", int'(a_dn_ts), 7);
        putt(1, 8, 0);
        #2;
        chk(a_dn_vld && a_dn_dummy && a_dn_ts == 8, "R8 equal dummies ts", int'(a_dn_ts), 8);
        idle(1);
        expect_cell(9, 9);
        expect_cell(10, 10);
        putt(0, 9, 9);
        #2;
        // R8 both dummies removed: xp empty now, tr holds real 9
        chk(!a_dn_vld, "R8 both popped", a_dn_vld, 0);
        putx(0, 10, 10);
        putt(1, 11, 0);
        idle(1);

        // Dummy overwrite and backpressure (R9, R10)
        a_dn_nack = 1;
        for (int i = 12; i <= 17; i++) putt(1, 8'(i), 0);
        #2;
        chk(!a_up_nack, "R9 dummies take no slots", a_up_nack, 0);
        for (int i = 18; i <= 21; i++) expect_cell(8'(i), 8'(i));
        putt(0, 18, 18);
        putt(0, 19, 19);
        putt(0, 20, 20);
        #2;
        chk(!a_up_nack, "R10 three real", a_up_nack, 0);
        putt(0, 21, 21);
        #2;
        chk(a_up_nack, "R10 full", a_up_nack, 1);
        chk(!a_dn_vld, "R3 hold full", a_dn_vld, 0);
        putx(1, 22, 0);
        a_dn_nack = 0;
        idle(1);
        #2;
        chk(!a_up_nack, "R10 falls after pop", a_up_nack, 0);
        idle(4);

        // Real against dummy with equal stamps (R7)
        expect_cell(23, 23);
        expect_cell(25, 25);
        expect_cell(27, 27);
        put(1, 0, 23, 23, 1, 1, 23, 0);
        #2;
        chk(a_dn_vld && !a_dn_dummy && a_dn_ts == 23, "R7 real xp beats dummy", int'(a_dn_tag), 23);
        putx(1, 24, 0);
        idle(1);
        put(1, 1, 25, 0, 1, 0, 25, 25);
        #2;
        chk(a_dn_vld && !a_dn_dummy && a_dn_tag == 25, "R7 real tr beats dummy", int'(a_dn_tag), 25);
        putt(0, 27, 27);
        #2;
        chk(a_dn_vld && a_dn_dummy && a_dn_ts == 25, "R7 older dummy first", int'(a_dn_ts), 25);
        putx(1, 28, 0);
        idle(1);

        // Equal-stamp real ties (R6)
        sb_on = 0;
        xw = 0;
        for (int i = 0; i < 240; i++) begin
            t = 8'(30 + 2 * i);
            put(1, 0, t, 8'hA0, 1, 0, t, 8'hB0);
            #2;
            chk(a_dn_vld && !a_dn_dummy && a_dn_ts == t, "R6 tie forwards one", int'(a_dn_ts), int'(t));
            if (a_dn_tag == 8'hA0) begin
                xw++;
                putx(1, t + 8'd1, 0);
            end else begin
                putt(1, t + 8'd1, 0);
            end
            idle(1);
        end
        chk(xw >= 50 && xw <= 110, "R6 crosspoint share near 1/3", xw, 80);

        // Stamp wrap (R5)
        sb_on = 1;
        expect_cell(254, 254);
        expect_cell(2, 2);
        put(1, 0, 254, 254, 1, 0, 2, 2);
        #2;
        chk(a_dn_vld && a_dn_ts == 254, "R5 wrap older first", int'(a_dn_ts), 254);
        putx(1, 3, 0);
        #2;
        chk(a_dn_vld && a_dn_ts == 2, "R5 wrap second", int'(a_dn_ts), 2);
        idle(3);
        chk(exp_q.size() == 0, "R4 all forwarded once", exp_q.size(), 0);

        // Top position (R11)
        b_in_vld = 1; b_in_dummy = 0; b_in_ts = 5; b_in_tag = 8'h51;
        idle(1);
        b_in_vld = 0;
        #2;
        chk(b_dn_vld && b_dn_tag == 8'h51, "R11 top forwards head", int'(b_dn_tag), 8'h51);
        chk(!b_up_nack, "R11 no nack at top", b_up_nack, 0);
        idle(1);
        b_dn_nack = 1;
        b_in_vld = 1; b_in_ts = 6; b_in_tag = 8'h52;
        b_up_vld = 1; b_up_ts = 0; b_up_tag = 8'h77;
        idle(1);
        b_in_vld = 0; b_up_vld = 0;
        #2;
        chk(!b_dn_vld, "R3 top hold", b_dn_vld, 0);
        b_dn_nack = 0;
        #1;
        chk(b_dn_vld && b_dn_tag == 8'h52, "R11 upper input ignored", int'(b_dn_tag), 8'h52);
        idle(2);

        done = 1;
        summary();
        $finish;
    end

endmodule